// File: doc/BRIEF.md
# Power-Management Command Port with SMI Trigger

This block provides two byte-wide registers that software reaches through a small I/O window. The port at even addresses is a command port: every byte written there is kept, and two reserved command codes ask the power-management logic to turn its SCI-enable flag on or off. When the SMI enable bit in a configuration byte is set, every command write also asks the processor for a system management interrupt. The port at odd addresses is a scratch status byte with no side effects. Both ports read back what was last written to them.

The block does not hold the SCI-enable flag. It sends one-cycle set and clear strobes to the register that does, and a one-cycle SMI request pulse to the interrupt logic. All three strobes are registered, so they appear in the cycle after the write is accepted. Read data is combinational from the selected register.

Top module: `apm_port_ctrl`

## Requirements
- R1: After synchronous active-low reset, both registers read 0x00 and `sci_set_o`, `sci_clr_o` and `smi_req_o` are low.
- R2: Only address bit 0 selects the register (0 = command port, 1 = status port). The upper address bits do not affect reads or writes.
- R3: A command-port write of 0xF1 drives `sci_set_o` high for exactly the one cycle that follows the write edge.
- R4: A command-port write of 0xF0 drives `sci_clr_o` high for exactly the one cycle that follows the write edge.
- R5: A command-port write of any value other than 0xF0 or 0xF1 produces neither SCI strobe.
- R6: A command-port write drives `smi_req_o` high for exactly one cycle after the write edge when bit 1 of `smi_cfg_i`, sampled with the write, is 1, whatever the data. When that bit is 0, no SMI request is produced.
- R7: A status-port write only stores the byte and produces no strobe of any kind.
- R8: Each register reads back, on `rdata_o`, the last byte written to it. The new value is visible from the cycle after the write edge.
- R9: `sci_set_o` and `sci_clr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| addr_i | input | 6 | Register address; only bit 0 is decoded |
| wdata_i | input | 8 | Write data |
| smi_cfg_i | input | 8 | Configuration byte; bit 1 enables the SMI request |
| rdata_o | output | 8 | Read data of the register selected by `addr_i` |
| sci_set_o | output | 1 | One-cycle request to set the SCI-enable flag |
| sci_clr_o | output | 1 | One-cycle request to clear the SCI-enable flag |
| smi_req_o | output | 1 | One-cycle SMI request |

## Verification
A wrong decode of the select bit shows up one cycle after the write. Either the strobes are missing after a command write, or a strobe follows a status write. A later read also returns the byte in the wrong register. A stuck or corrupted storage register shows only on the next read of that port, so the bench reads both ports after every write. A strobe that is missing, or too long, or that pairs set with clear, is visible in the first or second cycle after the write edge.

// File: rtl/apm_port_pkg.sv
// Shared constants and types for the power-management command port.
// Assumes byte-wide data; command codes are defined at 8 bits.
package apm_port_pkg;

    localparam int          NUM_PORTS   = 2;
    localparam logic [7:0]  CMD_SCI_ON  = 8'hF1;
    localparam logic [7:0]  CMD_SCI_OFF = 8'hF0;

    typedef enum logic {
        PORT_CMD  = 1'b0,
        PORT_STAT = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic cmd_wr;
        logic stat_wr;
        logic sci_on;
        logic sci_off;
        logic smi_fire;
    } wr_decode_t;

endpackage

// File: rtl/apm_port_decode.sv
// Write decoder: classifies a bus write by port and command code.
// Assumes ADDR_W >= 2 and that only address bit 0 carries meaning.
module apm_port_decode
    import apm_port_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 6,
    parameter int CFG_W      = 8,
    parameter int SMI_EN_BIT = 1
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CFG_W-1:0]  smi_cfg_i,
    output port_sel_e         sel_o,
    output wr_decode_t        dec_o
);

    logic unused_addr_hi;
    logic unused_cfg;

    assign unused_addr_hi = ^addr_i[ADDR_W-1:1];
    assign unused_cfg     = ^smi_cfg_i;

    // Port selection from the low address bit only.
    assign sel_o = port_sel_e'(addr_i[0]);

    // Classify the current write.
    always_comb begin
        dec_o          = '0;
        dec_o.cmd_wr   = wr_en_i && (sel_o == PORT_CMD);
        dec_o.stat_wr  = wr_en_i && (sel_o == PORT_STAT);
        dec_o.sci_on   = dec_o.cmd_wr && (wdata_i == DATA_W'(CMD_SCI_ON));
        dec_o.sci_off  = dec_o.cmd_wr && (wdata_i == DATA_W'(CMD_SCI_OFF));
        dec_o.smi_fire = dec_o.cmd_wr && smi_cfg_i[SMI_EN_BIT];
    end

endmodule

// File: rtl/apm_port_regs.sv
// Register bank: one byte register per port, with combinational read mux.
// Assumes at most one write enable is active per cycle.
module apm_port_regs
    import apm_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] wr_vec_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  port_sel_e            rsel_i,
    output logic [DATA_W-1:0]    cmd_q_o,
    output logic [DATA_W-1:0]    stat_q_o,
    output logic [DATA_W-1:0]    rdata_o
);

    logic [DATA_W-1:0] bank [NUM_PORTS];

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic [DATA_W-1:0] q;

        // Hold the last byte written to this port.
        always_ff @(posedge clk) begin
            if (!rst_n)           q <= '0;
            else if (wr_vec_i[g]) q <= wdata_i;
        end

        assign bank[g] = q;
    end

    assign cmd_q_o  = bank[PORT_CMD];
    assign stat_q_o = bank[PORT_STAT];

    // Read back the selected port.
    assign rdata_o = (rsel_i == PORT_CMD) ? bank[PORT_CMD] : bank[PORT_STAT];

endmodule

// File: rtl/apm_port_strobe.sv
// Strobe stage: registers the decoded side effects into one-cycle pulses.
// Assumes the decoder never asserts sci_on and sci_off together.
module apm_port_strobe
    import apm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wr_decode_t dec_i,
    output logic       sci_set_o,
    output logic       sci_clr_o,
    output logic       smi_req_o
);

    // Register each side effect for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_set_o <= 1'b0;
            sci_clr_o <= 1'b0;
            smi_req_o <= 1'b0;
        end else begin
            sci_set_o <= dec_i.sci_on;
            sci_clr_o <= dec_i.sci_off && !dec_i.sci_on;
            smi_req_o <= dec_i.smi_fire;
        end
    end

endmodule

// File: rtl/apm_port_ctrl.sv
// Top: power-management command/status port pair with SCI strobes and SMI pulse.
// Assumes a single-cycle write bus and a synchronous active-low reset.
module apm_port_ctrl
    import apm_port_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 6,
    parameter int CFG_W      = 8,
    parameter int SMI_EN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CFG_W-1:0]  smi_cfg_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              sci_set_o,
    output logic              sci_clr_o,
    output logic              smi_req_o
);

    port_sel_e            sel;
    wr_decode_t           dec;
    logic [NUM_PORTS-1:0] wr_vec;
    logic [DATA_W-1:0]    cmd_q;
    logic [DATA_W-1:0]    stat_q;

    apm_port_decode #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CFG_W      (CFG_W),
        .SMI_EN_BIT (SMI_EN_BIT)
    ) u_decode (
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .smi_cfg_i (smi_cfg_i),
        .sel_o     (sel),
        .dec_o     (dec)
    );

    // Pack per-port write enables in port-index order.
    always_comb begin
        wr_vec            = '0;
        wr_vec[PORT_CMD]  = dec.cmd_wr;
        wr_vec[PORT_STAT] = dec.stat_wr;
    end

    apm_port_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vec_i (wr_vec),
        .wdata_i  (wdata_i),
        .rsel_i   (sel),
        .cmd_q_o  (cmd_q),
        .stat_q_o (stat_q),
        .rdata_o  (rdata_o)
    );

    apm_port_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_i     (dec),
        .sci_set_o (sci_set_o),
        .sci_clr_o (sci_clr_o),
        .smi_req_o (smi_req_o)
    );

endmodule

// File: rtl/apm_port_ctrl_chk.sv
// Checker for apm_port_ctrl: temporal properties on ports and register state.
// Attached to every instance of the top through the bind at the end.
module apm_port_ctrl_chk #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 6,
    parameter int CFG_W      = 8,
    parameter int SMI_EN_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [CFG_W-1:0]  smi_cfg_i,
    input logic              sci_set_o,
    input logic              sci_clr_o,
    input logic              smi_req_o,
    input logic [DATA_W-1:0] cmd_q,
    input logic [DATA_W-1:0] stat_q
);

    logic cmd_w;
    logic stat_w;
    assign cmd_w  = wr_en_i && !addr_i[0];
    assign stat_w = wr_en_i &&  addr_i[0];

    AST_SCI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci_set_o && sci_clr_o));  // R9
    AST_SCI_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata_i == 8'hF1) |=> sci_set_o);  // R3
    AST_SCI_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata_i == 8'hF0) |=> sci_clr_o);  // R4
    AST_SCI_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_w && (wdata_i == 8'hF0 || wdata_i == 8'hF1)) |=> !sci_set_o && !sci_clr_o);  // R5
    AST_SMI_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && smi_cfg_i[SMI_EN_BIT]) |=> smi_req_o);  // R6
    AST_SMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_w && smi_cfg_i[SMI_EN_BIT]) |=> !smi_req_o);  // R6
    AST_STAT_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w |=> !sci_set_o && !sci_clr_o && !smi_req_o);  // R7
    AST_CMD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w |=> cmd_q == $past(wdata_i));  // R8
    AST_STAT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_w |=> stat_q == $past(wdata_i));  // R8
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_w |=> $stable(stat_q));  // R2

endmodule

bind apm_port_ctrl apm_port_ctrl_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CFG_W      (CFG_W),
    .SMI_EN_BIT (SMI_EN_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .smi_cfg_i (smi_cfg_i),
    .sci_set_o (sci_set_o),
    .sci_clr_o (sci_clr_o),
    .smi_req_o (smi_req_o),
    .cmd_q     (cmd_q),
    .stat_q    (stat_q)
);

// File: tb/tb_apm_port_ctrl.sv
// Bench for apm_port_ctrl: directed corners plus seeded random writes,
// checked against a reference model kept in bench variables.
module tb_apm_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [5:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] smi_cfg_i = '0;
    logic [7:0] rdata_o;
    logic       sci_set_o, sci_clr_o, smi_req_o;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] m_cmd = '0;
    logic [7:0] m_stat = '0;
    int unsigned seed_v;

    always #10 clk = ~clk;

    apm_port_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .smi_cfg_i (smi_cfg_i),
        .rdata_o   (rdata_o),
        .sci_set_o (sci_set_o),
        .sci_clr_o (sci_clr_o),
        .smi_req_o (smi_req_o)
    );

    function automatic logic exp_set(input logic [5:0] a, input logic [7:0] d);
        return !a[0] && d == 8'hF1;
    endfunction
    function automatic logic exp_clr(input logic [5:0] a, input logic [7:0] d);
        return !a[0] && d == 8'hF0;
    endfunction
    function automatic logic exp_smi(input logic [5:0] a, input logic [7:0] c);
        return !a[0] && c[1];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Read both ports with random upper address bits and compare (R2, R8).
    task automatic read_both(input string req);
        @(negedge clk);
        addr_i = {5'($urandom), 1'b0};
        #1 check(req, "cmd readback", rdata_o, m_cmd);
        addr_i = {5'($urandom), 1'b1};
        #1 check(req, "status readback", rdata_o, m_stat);
    endtask

    // One write, then strobe checks in the next two cycles (R3..R7).
    task automatic do_write(input string req, input logic [5:0] a,
                            input logic [7:0] d, input logic [7:0] c);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d; smi_cfg_i = c;
        @(negedge clk);
        wr_en_i = 1'b0; smi_cfg_i = 8'($urandom);
        if (a[0]) m_stat = d; else m_cmd = d;
        #1;
        check(req, "sci_set", {7'd0, sci_set_o}, {7'd0, exp_set(a, d)});
        check(req, "sci_clr", {7'd0, sci_clr_o}, {7'd0, exp_clr(a, d)});
        check(req, "smi_req", {7'd0, smi_req_o}, {7'd0, exp_smi(a, c)});
        @(negedge clk);
        #1 check(req, "strobes one cycle", {5'd0, sci_set_o, sci_clr_o, smi_req_o}, 8'd0);
    endtask

    initial begin
        #(20 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'h5EED_0A91);
        repeat (3) @(negedge clk);
        // R1: reset state
        #1 check("R1", "strobes at reset", {5'd0, sci_set_o, sci_clr_o, smi_req_o}, 8'd0);
        rst_n = 1'b1;
        read_both("R1");

        // Directed corners
        do_write("R3", 6'h00, 8'hF1, 8'h00);
        do_write("R4", 6'h3E, 8'hF0, 8'h00);
        do_write("R5", 6'h00, 8'hF2, 8'h00);
        do_write("R6", 6'h02, 8'h00, 8'h02);
        do_write("R6", 6'h00, 8'hF1, 8'hFD);
        do_write("R7", 6'h01, 8'hF1, 8'hFF);
        do_write("R2", 6'h3F, 8'hF0, 8'h02);
        read_both("R8");
        do_write("R9", 6'h10, 8'hF0, 8'h02);
        read_both("R8");

        // Seeded random traffic, biased toward the two command codes.
        for (int i = 0; i < 300; i++) begin
            logic [7:0] d;
            int unsigned pick;
            pick = $urandom % 4;
            d = (pick == 0) ? 8'hF1 : (pick == 1) ? 8'hF0 : 8'($urandom);
            do_write("R6", 6'($urandom), d, 8'($urandom));
            read_both("R8");
        end

        // Reset again mid-run returns to the reset state (R1).
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_cmd = '0; m_stat = '0;
        read_both("R1");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule